// File: doc/BRIEF.md
# Paged Packet Buffer Formatter

This block takes a received packet, delivered as a byte stream, and stores it in one page of a paged 2 KB buffer RAM. The stream marks its first byte with a start flag and its last byte with an end flag. Byte 0 is the sender's ID, byte 1 is the addressee's ID, and every later byte is payload. The page number is sampled with the first byte and becomes the upper address bits. Each page holds 256 bytes, so eight pages fill the RAM.

Inside a page the block writes a small header and then the payload. The payload is right-justified, so its last byte always lands on the final location of the page. The header has a count byte. For short packets the count is the payload's first offset. For long packets the count byte is zero and a second count byte gives the payload's first offset within a pair of pages. The start offset depends on the payload length, and the length is known only at the end flag. The block therefore stages the payload internally and writes it out after the packet closes, one RAM write per cycle. When it finishes it pulses a done flag. It pulses an error flag instead when the length has no valid format.

Top module: `pkt_page_formatter`

## Requirements
- R1: A short packet on page P writes RAM address P*256+0 with the source ID, P*256+1 with the destination ID, and P*256+2 with 256-N, where N is the payload length. Payload byte i goes to P*256+256-N+i, so the last byte sits at P*256+255.
- R2: The short format is used when N is from 1 to 253 inclusive.
- R3: The long format is used when N is from 257 to 508 inclusive and P is even. It covers the page pair starting at P*256. Offsets 0 and 1 hold the two IDs, offset 2 holds 0, and offset 3 holds 512-N. Payload byte i goes to offset 512-N+i, so the last byte is at offset 511.
- R4: A length of 0, 254, 255, 256 or more than 508 raises len_err for exactly one cycle, two cycles after the end byte is accepted. Such a packet causes no RAM write and no done. A packet made of a single byte counts as N=0.
- R5: A packet whose length needs the long format but whose page number is odd is rejected as in R4, with no RAM write.
- R6: The writes start two cycles after the end byte is accepted and come one per cycle with no gap. The order is the header bytes, then the payload from its lowest address upward. Locations between the count field and the first payload byte are never written.
- R7: done is high for exactly one cycle, in the cycle right after the final RAM write.
- R8: A byte with in_valid high is ignored in three cases: it arrives outside a packet without the start flag, it arrives in the cycle after an end byte, or it arrives while the write-out is in progress.
- R9: A start flag that arrives while a packet is still being collected discards the partial packet and begins a new one.
- R10: While reset is high, and after it is released until a packet ends, ram_we, done and len_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte present this cycle |
| in_sop | input | 1 | Byte is the first of a packet (source ID) |
| in_eop | input | 1 | Byte is the last of a packet |
| in_data | input | 8 | Stream byte |
| in_page | input | 3 | Target page, sampled with the first byte |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_addr | output | 11 | Buffer RAM byte address |
| ram_wdata | output | 8 | Buffer RAM write data |
| done | output | 1 | One-cycle pulse after the last write of a packet |
| len_err | output | 1 | One-cycle pulse for a rejected length or page |

## Verification
The embedded assertions check several properties on every cycle. A rejected packet never writes and its error flag never lasts beyond one cycle. Addresses within a write burst strictly increase. A short packet's upper address bits equal the sampled page. done always follows a write, and an odd page with a long length never starts a write-out. Other behaviours show up only in the bench's scenarios, because the bench's per-cycle model must predict every address and data byte. These are the exact header contents, the right-justification at both format boundaries, the position of every payload byte, the cycle-exact latency, and the dropping of stray, noise and restarted bytes.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    localparam int unsigned PBF_PAGES      = 8;
    localparam int unsigned PBF_PAGE_BYTES = 256;
    localparam int unsigned PBF_LEN_W      = 16;

    typedef logic [7:0] byte_t;

    // Header captured from the stream when a packet closes
    typedef struct packed {
        byte_t                 src_id;
        byte_t                 dst_id;
        logic [PBF_LEN_W-1:0]  n_data;
    } pkt_hdr_t;

    typedef enum logic [1:0] {
        LAY_SHORT  = 2'd0,
        LAY_LONG   = 2'd1,
        LAY_REJECT = 2'd2
    } layout_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_EMIT = 1'b1
    } wr_state_e;

    // Choose the in-page layout from payload length and page parity
    function automatic layout_e pick_layout(
        input logic [PBF_LEN_W-1:0] n,
        input logic                 page_odd,
        input int unsigned          page_bytes
    );
        int unsigned nv;
        nv = 32'(n);
        if (nv >= 1 && nv <= page_bytes - 3)
            return LAY_SHORT;
        if (nv >= page_bytes + 1 && nv <= 2 * page_bytes - 4)
            return page_odd ? LAY_REJECT : LAY_LONG;
        return LAY_REJECT;
    endfunction

    // Saturating increment for byte counters
    function automatic logic [PBF_LEN_W-1:0] sat_inc(input logic [PBF_LEN_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pbf_collect.sv
module pbf_collect
    import pbf_pkg::*;
#(
    parameter int unsigned PAGE_W      = 3,
    parameter int unsigned STORE_DEPTH = 512,
    localparam int unsigned IDX_W      = $clog2(STORE_DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  byte_t             in_data,
    input  logic [PAGE_W-1:0] in_page,
    input  logic              take_en,
    output pkt_hdr_t          hdr_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              pkt_valid_o,
    input  logic [IDX_W-1:0]  rd_idx,
    output byte_t             rd_data
);

    byte_t                 store_mem [STORE_DEPTH];
    logic                  active_q;
    logic [PBF_LEN_W-1:0]  seen_q;
    logic [PBF_LEN_W-1:0]  pos;
    logic [PBF_LEN_W-1:0]  data_pos;
    logic                  take;

    // A start flag always opens a packet; other bytes count only inside one
    assign take     = in_valid && take_en && (in_sop || active_q);
    assign pos      = in_sop ? '0 : seen_q;
    assign data_pos = pos - PBF_LEN_W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= 1'b0;
            seen_q      <= '0;
            pkt_valid_o <= 1'b0;
            hdr_o       <= '0;
            page_o      <= '0;
        end else begin
            pkt_valid_o <= 1'b0;
            if (take) begin
                seen_q <= sat_inc(pos);
                if (in_sop)
                    page_o <= in_page;
                if (pos == PBF_LEN_W'(0))
                    hdr_o.src_id <= in_data;
                if (pos == PBF_LEN_W'(1))
                    hdr_o.dst_id <= in_data;
                if (in_eop) begin
                    active_q     <= 1'b0;
                    pkt_valid_o  <= 1'b1;
                    hdr_o.n_data <= (pos >= PBF_LEN_W'(2)) ? sat_inc(data_pos) : '0;
                end else begin
                    active_q <= 1'b1;
                end
            end
        end
    end

    // Payload staging store
    always_ff @(posedge clk) begin
        if (take && pos >= PBF_LEN_W'(2) && data_pos < PBF_LEN_W'(STORE_DEPTH))
            store_mem[data_pos[IDX_W-1:0]] <= in_data;
    end

    assign rd_data = store_mem[rd_idx];

    AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !take_en) |=> $stable(seen_q)); // R8

    AST_CLOSE_PULSE: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_o |=> !pkt_valid_o); // R6

endmodule

// File: rtl/pbf_writer.sv
module pbf_writer
    import pbf_pkg::*;
#(
    parameter int unsigned PAGE_W     = 3,
    parameter int unsigned PAGE_BYTES = 256,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
    localparam int unsigned SPAN_W    = OFF_W + 1,
    localparam int unsigned ADDR_W    = PAGE_W + OFF_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid_i,
    input  pkt_hdr_t          hdr_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic [SPAN_W-1:0] rd_idx_o,
    input  byte_t             rd_data_i,
    output logic              busy_o,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output byte_t             ram_wdata,
    output logic              done_o,
    output logic              len_err_o
);

    wr_state_e          state_q;
    logic               long_q;
    logic [PAGE_W-1:0]  page_q;
    byte_t              sid_q;
    byte_t              did_q;
    logic [SPAN_W-1:0]  start_q;
    logic [SPAN_W-1:0]  step_q;
    logic [SPAN_W-1:0]  last_q;

    layout_e            lay_w;
    logic               long_w;
    logic [SPAN_W-1:0]  n_span;
    logic [SPAN_W-1:0]  hdr_len_w;
    logic [SPAN_W-1:0]  hdr_len;
    logic [SPAN_W-1:0]  off;

    // Classification of a freshly closed packet
    assign lay_w     = pick_layout(hdr_i.n_data, page_i[0], PAGE_BYTES);
    assign long_w    = (lay_w == LAY_LONG);
    assign n_span    = hdr_i.n_data[SPAN_W-1:0];
    assign hdr_len_w = long_w ? SPAN_W'(4) : SPAN_W'(3);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= WR_IDLE;
            long_q    <= 1'b0;
            page_q    <= '0;
            sid_q     <= '0;
            did_q     <= '0;
            start_q   <= '0;
            step_q    <= '0;
            last_q    <= '0;
            done_o    <= 1'b0;
            len_err_o <= 1'b0;
        end else begin
            done_o    <= 1'b0;
            len_err_o <= 1'b0;
            unique case (state_q)
                WR_IDLE: begin
                    if (pkt_valid_i) begin
                        if (lay_w == LAY_REJECT) begin
                            len_err_o <= 1'b1;
                        end else begin
                            state_q <= WR_EMIT;
                            long_q  <= long_w;
                            page_q  <= page_i;
                            sid_q   <= hdr_i.src_id;
                            did_q   <= hdr_i.dst_id;
                            // modulo 2*PAGE_BYTES: long start = 2P-N, short = P-N
                            start_q <= long_w ? (SPAN_W'(0) - n_span)
                                              : (SPAN_W'(PAGE_BYTES) - n_span);
                            step_q  <= '0;
                            last_q  <= hdr_len_w + n_span - SPAN_W'(1);
                        end
                    end
                end
                WR_EMIT: begin
                    if (step_q == last_q) begin
                        state_q <= WR_IDLE;
                        done_o  <= 1'b1;
                    end else begin
                        step_q <= step_q + SPAN_W'(1);
                    end
                end
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    // Write-out datapath
    assign hdr_len  = long_q ? SPAN_W'(4) : SPAN_W'(3);
    assign rd_idx_o = step_q - hdr_len;
    assign busy_o   = (state_q == WR_EMIT);
    assign ram_we   = busy_o;

    always_comb begin
        if (step_q < hdr_len)
            off = step_q;
        else
            off = start_q + (step_q - hdr_len);
    end

    always_comb begin
        if (long_q)
            ram_addr = {page_q[PAGE_W-1:1], off};
        else
            ram_addr = {page_q, off[OFF_W-1:0]};
    end

    always_comb begin
        if (step_q == SPAN_W'(0))
            ram_wdata = sid_q;
        else if (step_q == SPAN_W'(1))
            ram_wdata = did_q;
        else if (step_q == SPAN_W'(2))
            ram_wdata = long_q ? byte_t'(0) : byte_t'(start_q);
        else if (step_q == SPAN_W'(3) && long_q)
            ram_wdata = byte_t'(start_q);
        else
            ram_wdata = rd_data_i;
    end

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        len_err_o |-> !ram_we); // R4

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        len_err_o |=> !len_err_o); // R4

    AST_ODD_LONG_REJECT: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid_i && !busy_o && page_i[0] && hdr_i.n_data > PBF_LEN_W'(PAGE_BYTES))
        |=> !busy_o); // R5

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |-> (ram_addr > $past(ram_addr))); // R6

    AST_SHORT_PAGE: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !long_q) |-> (ram_addr[ADDR_W-1:OFF_W] == page_q)); // R1

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(ram_we) && !ram_we)); // R7

endmodule

// File: rtl/pkt_page_formatter.sv
module pkt_page_formatter
    import pbf_pkg::*;
#(
    parameter int unsigned PAGES      = PBF_PAGES,
    parameter int unsigned PAGE_BYTES = PBF_PAGE_BYTES,
    localparam int unsigned PAGE_W    = $clog2(PAGES),
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
    localparam int unsigned ADDR_W    = PAGE_W + OFF_W,
    localparam int unsigned STORE_D   = 2 * PAGE_BYTES,
    localparam int unsigned IDX_W     = $clog2(STORE_D)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [7:0]        in_data,
    input  logic [PAGE_W-1:0] in_page,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              done,
    output logic              len_err
);

    pkt_hdr_t           hdr;
    logic [PAGE_W-1:0]  pkt_page;
    logic               pkt_valid;
    logic               wr_busy;
    logic               take_en;
    logic [IDX_W-1:0]   rd_idx;
    byte_t              rd_data;

    // Input is closed while a packet awaits or undergoes write-out
    assign take_en = !wr_busy && !pkt_valid;

    pbf_collect #(
        .PAGE_W      (PAGE_W),
        .STORE_DEPTH (STORE_D)
    ) u_collect (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .in_data     (in_data),
        .in_page     (in_page),
        .take_en     (take_en),
        .hdr_o       (hdr),
        .page_o      (pkt_page),
        .pkt_valid_o (pkt_valid),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data)
    );

    pbf_writer #(
        .PAGE_W     (PAGE_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_writer (
        .clk         (clk),
        .rst         (rst),
        .pkt_valid_i (pkt_valid),
        .hdr_i       (hdr),
        .page_i      (pkt_page),
        .rd_idx_o    (rd_idx),
        .rd_data_i   (rd_data),
        .busy_o      (wr_busy),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .done_o      (done),
        .len_err_o   (len_err)
    );

    AST_NO_DONE_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
        !(done && len_err)); // R4

endmodule

// File: tb/pkt_page_formatter_tb.sv
module pkt_page_formatter_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sop, in_eop;
    logic [7:0]  in_data;
    logic [2:0]  in_page;
    logic        ram_we;
    logic [10:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        done, len_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;
    bit ended  = 1'b0;

    typedef struct packed {
        logic        we;
        logic [10:0] addr;
        logic [7:0]  data;
        logic        done;
        logic        err;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_page_formatter u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_page(in_page),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .done(done), .len_err(len_err)
    );

    function automatic logic [7:0] pay(int n, int i);
        return 8'((i * 13 + n * 5 + (i >> 8)) & 255);
    endfunction

    task automatic push(exp_t e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // Per-cycle expectation for one packet, starting at the negedge after the end byte is driven
    task automatic expect_pkt(int pg, int n, logic [7:0] sid, logic [7:0] did, string t);
        exp_t e;
        int   base, start;
        bit   short_ok, long_ok;
        short_ok = (n >= 1 && n <= 253);
        long_ok  = (n >= 257 && n <= 508) && (pg % 2 == 0);
        e = '0;
        push(e, {t, " R6 latency"});
        push(e, {t, " R6 latency"});
        if (!short_ok && !long_ok) begin
            e.err = 1'b1;
            push(e, {t, " R4 R5 reject"});
            return;
        end
        base  = short_ok ? pg * 256 : (pg & 6) * 256;
        start = short_ok ? 256 - n : 512 - n;
        e.we = 1'b1;
        e.addr = 11'(base);     e.data = sid;  push(e, {t, " R1 R3 src"});
        e.addr = 11'(base + 1); e.data = did;  push(e, {t, " R1 R3 dst"});
        e.addr = 11'(base + 2); e.data = short_ok ? 8'(start) : 8'h00;
        push(e, {t, " R1 R3 count"});
        if (long_ok) begin
            e.addr = 11'(base + 3); e.data = 8'(start); push(e, {t, " R3 count2"});
        end
        for (int i = 0; i < n; i++) begin
            e.addr = 11'(base + start + i);
            e.data = pay(n, i);
            push(e, {t, " R6 payload"});
        end
        e = '0;
        e.done = 1'b1;
        push(e, {t, " R7 done"});
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // n < 0 sends a lone start+end byte
    task automatic send_pkt(int pg, int n, bit noise, string t);
        int         total;
        logic [7:0] sid, did;
        total = (n < 0) ? 1 : n + 2;
        sid = 8'(8'hA0 + pg + n);
        did = 8'(8'h30 ^ n);
        for (int i = 0; i < total; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == total - 1);
            in_page  = 3'(pg);
            in_data  = (i == 0) ? sid : (i == 1) ? did : pay(n, i - 2);
        end
        expect_pkt(pg, n, sid, did, t);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        if (noise) begin
            for (int k = 0; k < 6; k++) begin
                @(posedge clk); #1;
                in_valid = 1'b1; in_sop = 1'b1; in_eop = (k == 5);
                in_data = 8'hEE; in_page = 3'(7 - pg);
            end
            @(posedge clk); #1;
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        end
        drain();
    endtask

    // Cycle-by-cycle comparison against the expectation queue
    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (mon_on && !ended) begin
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = '0;
                t = "R8 R10 idle";
            end
            checks++;
            if (ram_we !== e.we || (e.we && (ram_addr !== e.addr || ram_wdata !== e.data))
                || done !== e.done || len_err !== e.err) begin
                errors++;
                $display("FAIL %s: got we=%0b addr=%0h data=%0h done=%0b err=%0b, expected we=%0b addr=%0h data=%0h done=%0b err=%0b",
                         t, ram_we, ram_addr, ram_wdata, done, len_err,
                         e.we, e.addr, e.data, e.done, e.err);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL R6 watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_data = '0; in_page = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (ram_we !== 1'b0 || done !== 1'b0 || len_err !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: got we=%0b done=%0b err=%0b, expected 0 0 0", ram_we, done, len_err);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        mon_on = 1'b1;
        repeat (4) @(posedge clk);

        send_pkt(0, 1,   1'b0, "R2 short min");
        send_pkt(7, 253, 1'b0, "R2 short max");
        send_pkt(3, 100, 1'b1, "R8 noise during write-out");
        send_pkt(2, 257, 1'b0, "R3 long min");
        send_pkt(6, 508, 1'b0, "R3 long max");
        send_pkt(4, 300, 1'b0, "R3 long mid");
        send_pkt(5, 300, 1'b0, "R5 odd page long");
        send_pkt(1, 254, 1'b0, "R4 gap 254");
        send_pkt(1, 255, 1'b0, "R4 gap 255");
        send_pkt(0, 256, 1'b0, "R4 gap 256");
        send_pkt(2, 509, 1'b0, "R4 over 508");
        send_pkt(3, 0,   1'b0, "R4 empty payload");
        send_pkt(3, -1,  1'b0, "R4 lone byte");

        // Stray bytes outside a packet (R8)
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (k == 2); in_data = 8'h5A;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_eop = 1'b0;
        repeat (3) @(posedge clk);
        send_pkt(1, 20, 1'b0, "R8 after stray bytes");

        // Partial packet overridden by a new start (R9)
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_sop = (k == 0); in_eop = 1'b0;
            in_page = 3'd6; in_data = 8'(8'h11 * k);
        end
        send_pkt(2, 40, 1'b0, "R9 restart");

        send_pkt(4, 150, 1'b0, "R1 short mid");

        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule